// File: doc/BRIEF.md
# Output Driver Impedance Calibration Controller

This controller holds the two binary-weighted drive-strength codes of an output driver, one for the pull-up legs and one for the pull-down legs, and keeps them moving toward the setting that an external reference asks for. A free-running cycle timer raises a one-cycle evaluation strobe once per period. At each evaluation the controller samples one comparator result bit per leg and turns it into a single step of its code, up or down. Calibration never stops, so the codes follow slow drift in supply voltage and temperature.

A code may not change while its own leg is actively driving the pad. A step that cannot be applied at once is held pending. It is committed in the first cycle in which the driver state leaves that leg idle. A later evaluation replaces a pending step instead of adding to it, so a code never moves by more than one step per evaluation. Both codes saturate at their ends. The comparators, the reference resistor and the driver legs sit outside the block.

Top module: `zq_cal_ctrl`

## Requirements
- R1: `eval_o` is high for exactly one cycle out of every `PERIOD` cycles. It is first high in the `PERIOD`-th cycle after reset is released.
- R2: At an evaluation, each code's step direction comes from its comparator bit (1 = increase, 0 = decrease). No code moves by more than one step per evaluation.
- R3: `pu_code_o` changes only on a clock edge at which `drv_state_i` is 2'b00 (driving 0) or 2'b1x (high-Z).
- R4: `pd_code_o` changes only on a clock edge at which `drv_state_i` is 2'b01 (driving 1) or 2'b1x (high-Z).
- R5: A code at all-ones does not increase, and a code at all-zeros does not decrease. Neither code wraps.
- R6: While `rst_n` is low, both codes are 2^(W-1) (mid-scale) and `eval_o` is low.
- R7: A step that is blocked by the driver state is held pending. It is applied at the first later edge at which the leg is allowed to change. If the leg is allowed at the evaluation edge itself, the step is applied at that edge.
- R8: An evaluation that arrives while a step is still pending replaces that step. Pending steps do not add up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drv_state_i | input | 2 | Present driver output: 00 drives 0, 01 drives 1, 1x high-Z |
| pu_cmp_inc_i | input | 1 | Pull-up comparator: 1 asks for a larger code |
| pd_cmp_inc_i | input | 1 | Pull-down comparator: 1 asks for a larger code |
| pu_code_o | output | W | Pull-up drive-strength code |
| pd_code_o | output | W | Pull-down drive-strength code |
| eval_o | output | 1 | One-cycle evaluation strobe |

## Verification
The bench drives both codes into saturation in opposite directions. A design that wraps would jump from one end of the range to the other. It then holds the pull-down leg busy across many evaluations and releases it. A design that accumulated pending steps would jump by several codes, and one that dropped the pending step would not move at all. A long random phase toggles the driver state on nearly every cycle, so an update at the wrong edge or on the wrong leg shows up as a code mismatch against the behavioural model. The first strobe and the strobe spacing are compared on every cycle, which catches an off-by-one in the period.

// File: rtl/zq_cal_pkg.sv
package zq_cal_pkg;
  typedef enum logic [1:0] {
    DRV_LOW  = 2'b00,
    DRV_HIGH = 2'b01,
    DRV_HIZ  = 2'b10,
    DRV_HIZ2 = 2'b11
  } drv_state_e;

  // A leg may be retuned only while it is not driving the pad.
  function automatic logic leg_idle(input logic [1:0] state, input logic is_pullup);
    if (state[1]) return 1'b1;
    return is_pullup ? (state == DRV_LOW) : (state == DRV_HIGH);
  endfunction
endpackage

// File: rtl/zq_period_timer.sv
module zq_period_timer #(
  parameter int PERIOD = 256
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  AST_TICK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (cnt_q == '0)); // R1
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o); // R1
endmodule

// File: rtl/zq_leg_code.sv
module zq_leg_code #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         eval_i,
  input  logic         inc_i,
  input  logic         allow_i,
  output logic [W-1:0] code_o,
  output logic         pend_o,
  output logic         commit_o
);
  localparam logic [W-1:0] MID = W'(1) << (W - 1);

  function automatic logic [W-1:0] sat_step(input logic [W-1:0] c, input logic up);
    if (up)  return (c == '1) ? c : c + 1'b1;
    return (c == '0) ? c : c - 1'b1;
  endfunction

  logic         pend_q;
  logic         dir_q;
  logic [W-1:0] code_q;
  logic         req_v;
  logic         req_up;

  assign req_v    = eval_i | pend_q;
  assign req_up   = eval_i ? inc_i : dir_q;
  assign commit_o = req_v & allow_i;
  assign code_o   = code_q;
  assign pend_o   = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= MID;
      pend_q <= 1'b0;
      dir_q  <= 1'b0;
    end else if (commit_o) begin
      code_q <= sat_step(code_q, req_up);
      pend_q <= 1'b0;
    end else if (eval_i) begin
      pend_q <= 1'b1;
      dir_q  <= inc_i;
    end
  end

  AST_GATED_BY_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
    !allow_i |=> $stable(code_o)); // R3, R4
  AST_QUIET_WITHOUT_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    (!eval_i && !pend_o) |=> $stable(code_o)); // R2
  AST_NO_WRAP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (code_o == '1) |=> (code_o != '0)); // R5
  AST_NO_WRAP_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
    (code_o == '0) |=> (code_o != '1)); // R5
  AST_APPLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> !pend_o); // R7
  AST_BLOCKED_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && !allow_i) |=> pend_o); // R7
endmodule

// File: rtl/zq_cal_ctrl.sv
module zq_cal_ctrl #(
  parameter int PERIOD = 256,
  parameter int W      = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   drv_state_i,
  input  logic         pu_cmp_inc_i,
  input  logic         pd_cmp_inc_i,
  output logic [W-1:0] pu_code_o,
  output logic [W-1:0] pd_code_o,
  output logic         eval_o
);
  import zq_cal_pkg::*;

  localparam int NLEG = 2; // leg 0 pull-up, leg 1 pull-down

  logic         eval_w;
  logic [NLEG-1:0] inc_w;
  logic [NLEG-1:0] allow_w;
  logic [NLEG-1:0] pend_w;
  logic [NLEG-1:0] commit_w;
  logic [W-1:0] code_w [NLEG];

  zq_period_timer #(.PERIOD(PERIOD)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .tick_o(eval_w)
  );

  assign inc_w = {pd_cmp_inc_i, pu_cmp_inc_i};

  for (genvar g = 0; g < NLEG; g++) begin : g_leg
    assign allow_w[g] = leg_idle(drv_state_i, (g == 0));
    zq_leg_code #(.W(W)) u_leg (
      .clk     (clk),
      .rst_n   (rst_n),
      .eval_i  (eval_w),
      .inc_i   (inc_w[g]),
      .allow_i (allow_w[g]),
      .code_o  (code_w[g]),
      .pend_o  (pend_w[g]),
      .commit_o(commit_w[g])
    );
  end

  assign pu_code_o = code_w[0];
  assign pd_code_o = code_w[1];
  assign eval_o    = eval_w;

  AST_NEVER_BOTH_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_state_i[1] == 1'b0) |-> !(allow_w[0] && allow_w[1])); // R3
  AST_IDLE_IN_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    drv_state_i[1] |-> (allow_w == 2'b11)); // R4
endmodule

// File: tb/zq_cal_ctrl_tb.sv
module zq_cal_ctrl_tb;
  localparam int P   = 8;
  localparam int W   = 4;
  localparam int MAX = (1 << W) - 1;
  localparam int MID = 1 << (W - 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] st = 2'b10;
  logic pu_inc = 1'b0;
  logic pd_inc = 1'b0;
  logic [W-1:0] pu_code, pd_code;
  logic ev;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  int m_cnt, m_pu, m_pd;
  bit m_pu_pv, m_pu_up, m_pd_pv, m_pd_up;

  always #5 clk = ~clk;

  zq_cal_ctrl #(.PERIOD(P), .W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .drv_state_i(st),
    .pu_cmp_inc_i(pu_inc), .pd_cmp_inc_i(pd_inc),
    .pu_code_o(pu_code), .pd_code_o(pd_code), .eval_o(ev)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int stepc(input int c, input bit up);
    if (up) return (c < MAX) ? c + 1 : c;
    return (c > 0) ? c - 1 : c;
  endfunction

  // advance the model by one clock edge using the inputs now applied
  task automatic model_edge();
    bit e;
    bit pu_ok, pd_ok;
    e = (m_cnt == P - 1);
    pu_ok = st[1] || (st == 2'b00);
    pd_ok = st[1] || (st == 2'b01);
    if (e) begin m_pu_pv = 1; m_pu_up = pu_inc; m_pd_pv = 1; m_pd_up = pd_inc; end
    if (m_pu_pv && pu_ok) begin m_pu = stepc(m_pu, m_pu_up); m_pu_pv = 0; end
    if (m_pd_pv && pd_ok) begin m_pd = stepc(m_pd, m_pd_up); m_pd_pv = 0; end
    m_cnt = e ? 0 : m_cnt + 1;
  endtask

  initial begin
    m_cnt = 0; m_pu = MID; m_pd = MID;
    m_pu_pv = 0; m_pd_pv = 0; m_pu_up = 0; m_pd_up = 0;
    repeat (3) @(negedge clk);
    chk("R6 pu reset", int'(pu_code), MID);
    chk("R6 pd reset", int'(pd_code), MID);
    chk("R6 eval reset", int'(ev), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      if (i > 0) @(negedge clk);
      chk("R1 eval strobe", int'(ev), (m_cnt == P - 1) ? 1 : 0);
      chk("R2 R3 pull-up code", int'(pu_code), m_pu);
      chk("R2 R4 pull-down code", int'(pd_code), m_pd);
      if (i == P - 1) chk("R1 first strobe", int'(ev), 1);
      if (i == 199) begin
        chk("R5 pu saturates high", int'(pu_code), MAX);
        chk("R5 pd saturates low", int'(pd_code), 0);
      end
      if (i == 399) begin
        chk("R4 pd frozen while driving 0", int'(pd_code), 0);
        chk("R5 pu saturates low", int'(pu_code), 0);
      end
      if (i == 401) chk("R7 R8 single pending step applied", int'(pd_code), 1);
      if (i < 200) begin
        st = 2'b10; pu_inc = 1; pd_inc = 0;
      end else if (i < 400) begin
        st = 2'b00; pu_inc = 0; pd_inc = 1;
      end else if (i < 600) begin
        st = 2'b01; pu_inc = 1; pd_inc = 1;
      end else begin
        st = 2'($urandom_range(0, 3));
        pu_inc = 1'($urandom_range(0, 1));
        pd_inc = 1'($urandom_range(0, 1));
      end
      model_edge();
    end
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule